// File: doc/BRIEF.md
# Serial pseudo-SRAM bring-up sequencer

This block prepares an external serial pseudo-SRAM for use after a system reset. For a programmable settling window, counted in system-clock cycles, it holds the memory pins quiet. Chip select stays deasserted, the serial clock stays low and all four data lines are driven low. The block then sends the two-step software reset. The first step is an enable opcode (0x66) and the second is the reset opcode (0x99). Each opcode goes out in its own chip-select frame, one bit per serial clock, on data line 0. The two frames are separated by a programmable deselect gap.

When the second frame closes, the memory is taken to be in single-bit standby with linear bursts selected. The block then raises `ready` and keeps it high. `ready` also acts as the ownership flag: while it is high the sequencer drives none of the data lines, and the transaction engine may take over the pins. A new system reset discards any progress and starts the whole sequence again from the settling window.

Top module: `psram_boot_seq`

## Requirements
- R1: After reset is released, `cs_n` stays 1, `sck` stays 0, `dq_oe` is 4'b1111 and `dq_o` is 4'b0000 for exactly SETTLE_CYCLES clock cycles, with `busy`=1 and `ready`=0. `cs_n` falls on the following cycle.
- R2: The first frame carries 0x66. The frame has exactly 8 rising edges of `sck`, and `dq_o[0]` at each rising edge gives the byte MSB first.
- R3: The second frame carries 0x99 in the same bit order. Exactly two frames are sent, and no other `sck` activity occurs between them.
- R4: `dq_o[0]` changes only together with a falling (or absent) `sck` edge. It never changes on the cycle in which `sck` rises.
- R5: Between the two frames `cs_n` stays high for GAP_CYCLES+1 clock cycles, and never for fewer than GAP_CYCLES.
- R6: From the first frame until `ready` rises, `dq_oe` is 4'b0001. Lines 3..1 are released and only line 0 is driven.
- R7: On the cycle the second frame ends, `ready` becomes 1. From then on `cs_n`=1, `sck`=0 and `dq_oe`=4'b0000 hold for as long as reset stays released.
- R8: `busy` is the inverse of `ready` at all times.
- R9: Asserting reset at any point, including in the middle of a frame, returns the pins to the settling state on the next clock edge. After release the full sequence repeats.
- R10: `sck` pulses only while `cs_n` is 0, and `sck` is 0 at every edge of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| cs_n | output | 1 | Memory chip select, active low |
| sck | output | 1 | Memory serial clock |
| dq_o | output | 4 | Data line output values |
| dq_oe | output | 4 | Per-line output enable (1 = driven) |
| ready | output | 1 | Sequence finished; pins owned by the transaction engine |
| busy | output | 1 | Sequence in progress |

## Verification
The embedded properties assume that `rst_n` is the only control input and that it changes synchronously to `clk`. The properties are disabled while it is low, so they say nothing about the cycle in which reset is taken. The stimulus changes `rst_n` only on falling clock edges. It releases reset once with the sequence left to run to completion. It also cuts a frame short in mid-byte and then lets the repeated sequence finish. Expected serial bits are queued from the two opcode values and compared at each rising `sck` seen at a falling system-clock edge.

// File: rtl/psram_boot_pkg.sv
package psram_boot_pkg;

    typedef enum logic [2:0] {
        PH_SETTLE = 3'd0,
        PH_SHIFT  = 3'd1,
        PH_GAP    = 3'd2,
        PH_READY  = 3'd3
    } boot_phase_e;

    localparam logic [7:0] OPC_RESET_ARM = 8'h66;
    localparam logic [7:0] OPC_RESET_GO  = 8'h99;

    localparam int unsigned FRAME_BITS = 8;

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned INIT_VAL = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // A load always replaces the count on the following edge
    AST_TIMER_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));                         // R5

endmodule

// File: rtl/boot_shifter.sv
module boot_shifter
    import psram_boot_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_i,
    output logic       sck_o,
    output logic       bit_o,
    output logic       active_o,
    output logic       done_o
);

    localparam int unsigned DIV_W  = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int unsigned BCNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic              active;
        logic              sck;
        logic [7:0]        bits;
        logic [BCNT_W-1:0] bcnt;
        logic [DIV_W-1:0]  div;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         half_end;
    logic         done_d;

    assign half_end = (st_q.div == DIV_W'(HALF_CYCLES - 1));

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.sck    = 1'b0;
            st_d.bits   = byte_i;
            st_d.bcnt   = '0;
            st_d.div    = '0;
        end else if (st_q.active) begin
            if (half_end) begin
                st_d.div = '0;
                if (!st_q.sck) begin
                    st_d.sck = 1'b1;
                end else begin
                    st_d.sck  = 1'b0;
                    st_d.bits = {st_q.bits[6:0], 1'b0};
                    st_d.bcnt = st_q.bcnt + 1'b1;
                    if (st_q.bcnt == BCNT_W'(FRAME_BITS - 1)) begin
                        st_d.active = 1'b0;
                        done_d      = 1'b1;
                    end
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o    = st_q.sck;
    assign bit_o    = st_q.active & st_q.bits[7];
    assign active_o = st_q.active;
    assign done_o   = done_d;

    // Data may only move on the falling half; never at the rising edge
    AST_DATA_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(bit_o));                             // R4

    // The serial clock is idle low whenever no frame is in flight
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !sck_o);                                        // R10

endmodule

// File: rtl/psram_boot_seq.sv
module psram_boot_seq
    import psram_boot_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES   = 18750,
    parameter int unsigned GAP_CYCLES      = 7,
    parameter int unsigned SCK_HALF_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       cs_n,
    output logic       sck,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe,
    output logic       ready,
    output logic       busy
);

    localparam int unsigned TMR_MAX = (SETTLE_CYCLES > GAP_CYCLES) ? SETTLE_CYCLES : GAP_CYCLES;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
    localparam int unsigned GCHK_W  = $clog2(GAP_CYCLES + 2) + 1;

    typedef struct packed {
        boot_phase_e ph;
        logic        second;
        logic        cs_n;
        logic        ready;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             sh_start;
    logic [7:0]       sh_byte;
    logic             sh_sck;
    logic             sh_bit;
    logic             sh_active;
    logic             sh_done;

    boot_timer #(
        .CNT_W    (TMR_W),
        .INIT_VAL (SETTLE_CYCLES)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    boot_shifter #(
        .HALF_CYCLES (SCK_HALF_CYCLES)
    ) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .byte_i   (sh_byte),
        .sck_o    (sh_sck),
        .bit_o    (sh_bit),
        .active_o (sh_active),
        .done_o   (sh_done)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(GAP_CYCLES);
        sh_start = 1'b0;
        sh_byte  = OPC_RESET_ARM;
        unique case (ctl_q.ph)
            PH_SETTLE: begin
                if (tmr_zero) begin
                    sh_start     = 1'b1;
                    sh_byte      = OPC_RESET_ARM;
                    ctl_d.cs_n   = 1'b0;
                    ctl_d.second = 1'b0;
                    ctl_d.ph     = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                if (sh_done) begin
                    ctl_d.cs_n = 1'b1;
                    if (!ctl_q.second) begin
                        tmr_load = 1'b1;
                        ctl_d.ph = PH_GAP;
                    end else begin
                        ctl_d.ready = 1'b1;
                        ctl_d.ph    = PH_READY;
                    end
                end
            end
            PH_GAP: begin
                if (tmr_zero) begin
                    sh_start     = 1'b1;
                    sh_byte      = OPC_RESET_GO;
                    ctl_d.cs_n   = 1'b0;
                    ctl_d.second = 1'b1;
                    ctl_d.ph     = PH_SHIFT;
                end
            end
            PH_READY: begin
                ctl_d = ctl_q;
            end
            default: begin
                ctl_d.ph = PH_SETTLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ph     <= PH_SETTLE;
            ctl_q.second <= 1'b0;
            ctl_q.cs_n   <= 1'b1;
            ctl_q.ready  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (ctl_q.ph)
            PH_SETTLE:        dq_oe = 4'b1111;
            PH_SHIFT, PH_GAP: dq_oe = 4'b0001;
            default:          dq_oe = 4'b0000;
        endcase
    end

    assign dq_o  = {3'b000, sh_bit};
    assign cs_n  = ctl_q.cs_n;
    assign sck   = sh_sck;
    assign ready = ctl_q.ready;
    assign busy  = ~ctl_q.ready;

    // Length of the deselect interval, counted for the gap check
    logic [GCHK_W-1:0] gap_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt_q <= '0;
        end else if (!cs_n) begin
            gap_cnt_q <= '0;
        end else if (gap_cnt_q != '1) begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SETTLE) |-> (!sh_sck && !sh_active && cs_n));  // R1

    AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sh_sck |-> !cs_n);                                             // R10

    AST_GAP_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && ctl_q.second) |-> (gap_cnt_q >= GCHK_W'(GAP_CYCLES))); // R5

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);                                              // R7

    AST_READY_PINS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && !sh_sck && !sh_active));                    // R7

    AST_CS_RISES_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(sh_done));                               // R2

endmodule

// File: tb/test_psram_boot_seq.sv
module test_psram_boot_seq;

    localparam int unsigned SETTLE = 300;
    localparam int unsigned GAP    = 5;
    localparam int unsigned HALF   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n, sck, ready, busy;
    logic [3:0] dq_o, dq_oe;

    always #4 clk = ~clk;

    psram_boot_seq #(
        .SETTLE_CYCLES   (SETTLE),
        .GAP_CYCLES      (GAP),
        .SCK_HALF_CYCLES (HALF)
    ) i_psram_boot_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .dq_o  (dq_o),
        .dq_oe (dq_oe),
        .ready (ready),
        .busy  (busy)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    exp_bit_q[$];
    string exp_req_q[$];
    logic  prev_sck = 1'b0;
    logic  prev_cs  = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue the serial bits MSB first
    task automatic push_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            exp_bit_q.push_back(b[i]);
            exp_req_q.push_back(req);
        end
    endtask

    task automatic load_expected();
        exp_bit_q.delete();
        exp_req_q.delete();
        push_byte(8'h66, "R2");
        push_byte(8'h99, "R3");
    endtask

    // Monitor side: compare data line 0 at each rising serial clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck && !prev_sck) begin
                check(!cs_n, "R10", "sck rose with cs_n high", cs_n, 0);
                if (exp_bit_q.size() == 0) begin
                    check(1'b0, "R3", "extra sck rising edge", 1, 0);
                end else begin
                    automatic bit    e = exp_bit_q.pop_front();
                    automatic string r = exp_req_q.pop_front();
                    check(dq_o[0] == e, r, "serial bit", dq_o[0], e);
                end
            end
            if (cs_n != prev_cs) begin
                check(!sck, "R10", "sck high at cs_n edge", sck, 0);
            end
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic run_sequence();
        int cnt;
        int bad;
        cnt = 0;
        bad = 0;
        @(negedge clk);
        while (cs_n && cnt <= SETTLE + 10) begin
            if (sck !== 1'b0 || dq_oe !== 4'hF || dq_o !== 4'h0 || busy !== 1'b1 || ready !== 1'b0)
                bad++;
            cnt++;
            @(negedge clk);
        end
        check(cnt == SETTLE, "R1", "settle cycles", cnt, SETTLE);
        check(bad == 0, "R1", "pins during settle", bad, 0);
        check(dq_oe == 4'b0001, "R6", "oe in first frame", dq_oe, 1);
        check(busy == !ready, "R8", "busy vs ready", busy, !ready);
        while (!cs_n) @(negedge clk);
        check(exp_bit_q.size() == 8, "R2", "bits left after first frame", exp_bit_q.size(), 8);
        cnt = 0;
        bad = 0;
        while (cs_n && cnt < 100) begin
            if (dq_oe !== 4'b0001 || sck !== 1'b0 || busy !== 1'b1) bad++;
            cnt++;
            @(negedge clk);
        end
        check(cnt == GAP + 1, "R5", "gap cycles", cnt, GAP + 1);
        check(bad == 0, "R6", "pins during gap", bad, 0);
        check(dq_oe == 4'b0001, "R6", "oe in second frame", dq_oe, 1);
        while (!cs_n) @(negedge clk);
        check(exp_bit_q.size() == 0, "R3", "bits left after second frame", exp_bit_q.size(), 0);
        check(ready == 1'b1, "R7", "ready at frame end", ready, 1);
        check(busy == 1'b0, "R8", "busy at frame end", busy, 0);
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (!cs_n || sck || dq_oe !== 4'h0 || !ready || busy) bad++;
        end
        check(bad == 0, "R7", "idle hold after ready", bad, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(cs_n && !sck && dq_oe == 4'hF && dq_o == 4'h0, "R1", "pins in reset",
              {cs_n, sck, dq_oe}, 6'b101111);
        check(busy && !ready, "R8", "flags in reset", {busy, ready}, 2'b10);
        load_expected();
        rst_n = 1'b1;
        run_sequence();

        // Restart in the middle of the first frame
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        load_expected();
        rst_n = 1'b1;
        while (cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n && !sck && dq_oe == 4'hF && busy, "R9", "pins after mid-frame reset",
              {cs_n, sck, dq_oe, busy}, 7'b1011111);
        repeat (3) @(negedge clk);
        load_expected();
        rst_n = 1'b1;
        run_sequence();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule